// File: doc/BRIEF.md
# PCI Interrupt Line Router

The router steers four shared PCI interrupt request lines (lines A, B, C and D, indexed 0 to 3) onto sixteen legacy interrupt-controller inputs. Each line has a byte-wide steering register. A steering value from 0 to 15 connects the line to that controller input. A value of 16 or more leaves the line unconnected, and its level is then ignored. Several lines may share one controller input. That input is then the wired OR of every line steered to it.

A 64-bit level map holds the live state. Bit `irq*4 + line` is set while line `line` is high and steered to input `irq`. Each controller output is the registered OR of its four map bits. When a line changes level, only the map bit at its current destination is updated. Any write into the steering window clears the map. The map is then rebuilt from the live line levels under the new steering, and all sixteen outputs are driven again.

Two combinational helpers come with the block. The first is a route query, which reports whether a line is connected and to which input. The second is a slot swizzle, which maps a device/function number and an INTx pin to a line index.

Top module: `pirq_router`

## Requirements
- R1: A synchronous reset sets every steering byte to 0x80, clears the level map and drives all sixteen outputs low.
- R2: The steering bytes for lines 0 to 3 sit at byte offsets 0x60, 0x61, 0x62 and 0x63, in that order. A read at one of these offsets returns the last byte written there, unchanged.
- R3: When a line is steered to input n (a value below 16), output n follows that line's level one clock after the level is sampled.
- R4: A steering byte of 16 or more disconnects its line. That line then drives no output, whatever its level.
- R5: An output shared by several lines stays high while any of them is high. It falls only when all of them are low.
- R6: A write into the steering window changes the routing at the next clock edge. In that same cycle the old destination is released and the new destination takes the line's live level.
- R7: Writes outside 0x60 to 0x63 leave every steering byte and every output unchanged. Reads outside the window return 0.
- R8: The route query for a line reports enabled together with the input number when its steering byte is below 16. Otherwise it reports disabled with input number 0.
- R9: The swizzle output equals (pin + (devfn >> 3) - 1) mod 4. Device number 0 wraps to line (pin + 3) mod 4.
- R10: A level change on one line leaves outputs that only other lines drive unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pirq_level | input | 4 | Live levels of lines 0..3 |
| cfg_wr | input | 1 | Byte write strobe |
| cfg_addr | input | 8 | Byte offset for read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr (combinational) |
| irq_out | output | 16 | Registered controller input levels |
| query_pin | input | 2 | Line index for the route query |
| query_en | output | 1 | Queried line is connected |
| query_irq | output | 4 | Destination input of the queried line |
| sw_devfn | input | 8 | Device/function number for the swizzle |
| sw_pin | input | 2 | INTx pin for the swizzle (0 = INTA) |
| sw_pirq | output | 2 | Line index from the swizzle |

## Verification
The bench targets the boundary between 15 and 16 in a steering byte. A design that compared against the wrong bound would leave a line connected to input 0 or drop input 15. It shares one input between two lines and lowers them one at a time. A design that tracked levels per input instead of per line would drop the output too early. It steers a line that is already high and then moves it. A design that skipped the rebuild would miss the new input or leave a stale bit behind on the old one. It also checks writes just outside the window, and every device number through the swizzle, where device 0 exposes a missing wrap.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NUM_PIRQ    = 4,
  parameter int NUM_IRQ     = 16,
  parameter int ADDR_W      = 8,
  parameter int BASE_ADDR   = 'h60,
  parameter int RESET_ROUTE = 'h80
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PIRQ-1:0]         pirq_level,
  input  logic                        cfg_wr,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [7:0]                  cfg_wdata,
  output logic [7:0]                  cfg_rdata,
  output logic [NUM_IRQ-1:0]          irq_out,
  input  logic [$clog2(NUM_PIRQ)-1:0] query_pin,
  output logic                        query_en,
  output logic [$clog2(NUM_IRQ)-1:0]  query_irq,
  input  logic [7:0]                  sw_devfn,
  input  logic [$clog2(NUM_PIRQ)-1:0] sw_pin,
  output logic [$clog2(NUM_PIRQ)-1:0] sw_pirq
);
  localparam int PW    = $clog2(NUM_PIRQ);
  localparam int IW    = $clog2(NUM_IRQ);
  localparam int MAP_W = NUM_PIRQ * NUM_IRQ;
  localparam int MW    = $clog2(MAP_W);

  logic [NUM_PIRQ*8-1:0] route_q, route_d;
  logic [MAP_W-1:0]      map_q, map_d;
  logic [NUM_IRQ-1:0]    irq_d;
  logic [NUM_PIRQ-1:0]   sel, en_d;
  logic [ADDR_W-1:0]     off;
  logic                  in_win, rebuild;
  logic [7:0]            qbyte, sw_sum;

  assign off     = cfg_addr - ADDR_W'(BASE_ADDR);
  assign in_win  = (int'(cfg_addr) >= BASE_ADDR) && (int'(cfg_addr) < BASE_ADDR + NUM_PIRQ);
  assign rebuild = cfg_wr && in_win;

  for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_line
    assign sel[p] = in_win && (off[PW-1:0] == PW'(p));
    assign route_d[p*8 +: 8] = (cfg_wr && sel[p]) ? cfg_wdata : route_q[p*8 +: 8];
    assign en_d[p] = route_d[p*8 +: 8] < 8'(NUM_IRQ);
  end

  always_comb begin
    map_d = rebuild ? '0 : map_q;
    for (int p = 0; p < NUM_PIRQ; p++) begin
      if (en_d[p]) map_d[MW'({route_d[p*8 +: IW], PW'(p)})] = pirq_level[p];
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign irq_d[i] = |map_d[i*NUM_PIRQ +: NUM_PIRQ];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= {NUM_PIRQ{8'(RESET_ROUTE)}};
      map_q   <= '0;
      irq_out <= '0;
    end else begin
      route_q <= route_d;
      map_q   <= map_d;
      irq_out <= irq_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    qbyte     = '0;
    for (int p = 0; p < NUM_PIRQ; p++) begin
      if (sel[p]) cfg_rdata = route_q[p*8 +: 8];
      if (query_pin == PW'(p)) qbyte = route_q[p*8 +: 8];
    end
  end

  assign query_en  = qbyte < 8'(NUM_IRQ);
  assign query_irq = query_en ? qbyte[IW-1:0] : '0;

  assign sw_sum  = 8'(sw_pin) + {3'b000, sw_devfn[7:3]} - 8'd1;
  assign sw_pirq = sw_sum[PW-1:0];
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int NUM_PIRQ  = 4,
  parameter int NUM_IRQ   = 16,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h60
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_PIRQ-1:0]   pirq_level,
  input logic                  cfg_wr,
  input logic [ADDR_W-1:0]     cfg_addr,
  input logic [7:0]            cfg_wdata,
  input logic [NUM_IRQ-1:0]    irq_out,
  input logic [NUM_PIRQ*8-1:0] route_q
);
  localparam int IW = $clog2(NUM_IRQ);

  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int p = 0; p < NUM_PIRQ; p++)
      if (route_q[p*8 +: 8] < 8'(NUM_IRQ)) all_off = 1'b0;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_out == '0));

  // R3
  follow_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_wr && route_q[7:0] < 8'(NUM_IRQ) && pirq_level[0]) |=> irq_out[$past(route_q[IW-1:0])]);

  // R4
  all_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_wr && all_off) |=> (irq_out == '0));

  // R5
  needs_source_chk: assert property (@(posedge clk) disable iff (rst)
    (|irq_out) |-> $past(|pirq_level));

  // R6
  reroute_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == ADDR_W'(BASE_ADDR) && cfg_wdata < 8'(NUM_IRQ) && pirq_level[0])
      |=> irq_out[$past(cfg_wdata[IW-1:0])]);
endmodule

bind pirq_router pirq_router_chk #(
  .NUM_PIRQ(NUM_PIRQ), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .pirq_level(pirq_level), .cfg_wr(cfg_wr),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_out(irq_out), .route_q(route_q)
);

// File: tb/sim_pirq_router.sv
`timescale 1ns/1ps
module sim_pirq_router;
  logic        clk = 0;
  logic        rst = 1;
  logic [3:0]  pirq_level = '0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] irq_out;
  logic [1:0]  query_pin = '0;
  logic        query_en;
  logic [3:0]  query_irq;
  logic [7:0]  sw_devfn = '0;
  logic [1:0]  sw_pin = '0;
  logic [1:0]  sw_pirq;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pirq_router u0 (
    .clk(clk), .rst(rst), .pirq_level(pirq_level), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_out(irq_out), .query_pin(query_pin), .query_en(query_en),
    .query_irq(query_irq), .sw_devfn(sw_devfn), .sw_pin(sw_pin), .sw_pirq(sw_pirq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic lvl(logic [3:0] v);
    pirq_level = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int p = 0; p < 4; p++) begin
      rd(8'h60 + 8'(p), d);
      check("R1 reset route", d, 8'h80);
    end
    check("R1 reset outputs", irq_out, 0);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    wr(8'h60, 8'h83); wr(8'h61, 8'h91); wr(8'h62, 8'hA2); wr(8'h63, 8'hF0);
    rd(8'h60, d); check("R2 readback A", d, 8'h83);
    rd(8'h61, d); check("R2 readback B", d, 8'h91);
    rd(8'h62, d); check("R2 readback C", d, 8'hA2);
    rd(8'h63, d); check("R2 readback D", d, 8'hF0);
    lvl(4'hF); lvl(4'hF);
    check("R4 disabled lines high", irq_out, 0);
    wr(8'h64, 8'h05); wr(8'h5F, 8'h05);
    @(posedge clk); #1;
    check("R7 outside write no output", irq_out, 0);
    rd(8'h60, d); check("R7 route A intact", d, 8'h83);
    rd(8'h63, d); check("R7 route D intact", d, 8'hF0);
    rd(8'h64, d); check("R7 outside read zero", d, 0);
    lvl(4'h0);
  endtask

  task automatic t_follow;
    wr(8'h60, 8'h03);
    check("R3 low line after steer", irq_out, 0);
    lvl(4'h1); check("R3 line A high", irq_out, 16'h0008);
    lvl(4'h0); check("R3 line A low", irq_out, 0);
  endtask

  task automatic t_share;
    wr(8'h60, 8'h05); wr(8'h61, 8'h05); wr(8'h62, 8'h07);
    lvl(4'h3); check("R5 both high", irq_out, 16'h0020);
    lvl(4'h7); check("R10 C added", irq_out, 16'h00A0);
    lvl(4'h3); check("R10 C removed, 5 kept", irq_out, 16'h0020);
    lvl(4'h2); check("R5 A low, B holds", irq_out, 16'h0020);
    lvl(4'h0); check("R5 both low", irq_out, 0);
  endtask

  task automatic t_reroute;
    wr(8'h62, 8'h80);
    lvl(4'h4); check("R4 C disabled high", irq_out, 0);
    wr(8'h62, 8'h09); check("R6 steer live line", irq_out, 16'h0200);
    wr(8'h62, 8'h02); check("R6 move releases old", irq_out, 16'h0004);
    wr(8'h62, 8'h10); check("R4 value 16 disables", irq_out, 0);
    wr(8'h62, 8'h0F); check("R4 value 15 enabled", irq_out, 16'h8000);
    lvl(4'h0);
  endtask

  task automatic t_query;
    wr(8'h60, 8'h0C); wr(8'h61, 8'h10); wr(8'h62, 8'h00); wr(8'h63, 8'hFF);
    query_pin = 0; #1; check("R8 query A", {query_en, query_irq}, {1'b1, 4'hC});
    query_pin = 1; #1; check("R8 query B", {query_en, query_irq}, {1'b0, 4'h0});
    query_pin = 2; #1; check("R8 query C", {query_en, query_irq}, {1'b1, 4'h0});
    query_pin = 3; #1; check("R8 query D", {query_en, query_irq}, {1'b0, 4'h0});
  endtask

  task automatic t_swizzle;
    for (int dev = 0; dev < 32; dev++) begin
      for (int pin = 0; pin < 4; pin++) begin
        sw_devfn = 8'(dev << 3) | 8'(dev % 8);
        sw_pin = 2'(pin);
        #1;
        check("R9 swizzle", sw_pirq, 32'((pin + dev + 3) % 4));
      end
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_disabled();
    t_follow();
    t_share();
    t_reroute();
    t_query();
    t_swizzle();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule